// File: doc/BRIEF.md
# Interrupt Vector Table Arbiter

This block stores one word-aligned vector address for each interrupt source. All the vectors sit in a single-port RAM. Three clients share that RAM: a fast-interrupt lookup engine, a normal-interrupt lookup engine and a memory-mapped register port. A lookup engine raises a request with an interrupt index. One cycle after the request is granted, the engine's valid flag rises and the stored vector appears on the engine's data output and on a shared vector-address output.

The register port uses a valid/ready handshake. A write that falls in the table window is parked in a one-entry posted-write buffer, and the port releases it at once. Any later register access waits until that buffered word has reached the RAM. A read issues a RAM access when the RAM is free and completes on the following cycle. A readback therefore always confirms that an earlier write has landed. Lookups always take precedence over the register port, so the register port can be starved while lookups arrive back to back.

Top module: `irq_vec_table`

## Requirements
- R1: After reset every table entry reads as 0 through both lookups and the register port, `fiq_vld`/`irq_vld` are low and `vec_addr` is 0.
- R2: When `fiq_req` is high at a clock edge with index `fiq_idx`, on the next cycle `fiq_vld` is 1 and `fiq_vec` holds that entry.
- R3: Fast lookups win over normal lookups, and both win over the register port. `irq_vld` rises one cycle after an edge where `irq_req` is high and `fiq_req` is low. It never rises together with `fiq_vld`.
- R4: `vec_addr` shows the returned vector in the cycle its valid flag is high, and keeps the last returned vector afterwards.
- R5: A register write inside the window completes in the same cycle it is presented (`reg_ready`=1) whenever the posted-write buffer is empty.
- R6: Bits 1:0 of every stored vector read back as 0, whatever value was written to them.
- R7: While the buffer holds a write, further in-window register accesses are stalled. The buffer commits to the RAM in the first cycle with neither lookup request high.
- R8: Lookups return the old vector until the buffered write has been committed, and the new vector afterwards.
- R9: An in-window read completes one cycle after its RAM access is issued. A read that follows a write returns the written value.
- R10: The window is byte addresses BASE to BASE+ENTRIES*4-1, with entry Q at BASE+4Q. Accesses outside the window complete in the same cycle, reads return 0 and writes change nothing.
- R11: While a lookup request is high in every cycle, a buffered write stays uncommitted and a pending register read does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_req | input | 1 | Fast-interrupt lookup request |
| fiq_idx | input | IW | Fast-interrupt index |
| fiq_vld | output | 1 | Fast lookup result valid |
| fiq_vec | output | DW | Fast lookup vector (meaningful while fiq_vld) |
| irq_req | input | 1 | Normal-interrupt lookup request |
| irq_idx | input | IW | Normal-interrupt index |
| irq_vld | output | 1 | Normal lookup result valid |
| irq_vec | output | DW | Normal lookup vector (meaningful while irq_vld) |
| vec_addr | output | DW | Vector of the active (most recent) lookup |
| reg_valid | input | 1 | Register access present |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | RAW | Register byte address |
| reg_wdata | input | DW | Write data |
| reg_ready | output | 1 | Access completes this cycle |
| reg_rdata | output | DW | Read data, valid when reg_ready for a read |

## Verification
The hardest situation to reach is a posted write held back by continuous lookups while a register read waits behind it. In the bench, the fast engine keeps its request asserted on the entry just written, and the normal engine requests the same entry. A read of that entry is queued meanwhile. The bench then checks that the lookups still see the old vector and that the read stays stalled. After the requests drop, it checks that the commit, the read issue and the completion follow on exactly one cycle each.

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int ENTRIES = 256,
  parameter int DW      = 32,
  parameter int RAW     = 12,
  parameter int BASE    = 'h400,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fiq_req,
  input  logic [IW-1:0] fiq_idx,
  output logic          fiq_vld,
  output logic [DW-1:0] fiq_vec,
  input  logic          irq_req,
  input  logic [IW-1:0] irq_idx,
  output logic          irq_vld,
  output logic [DW-1:0] irq_vec,
  output logic [DW-1:0] vec_addr,
  input  logic          reg_valid,
  input  logic          reg_write,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          reg_ready,
  output logic [DW-1:0] reg_rdata
);
  localparam int SW = DW - 2;
  localparam logic [RAW:0] LO = BASE[RAW:0];
  localparam logic [RAW:0] HI = LO + (RAW+1)'(ENTRIES * 4);

  logic [SW-1:0] mem [ENTRIES];
  logic [SW-1:0] q_r, last_r, wb_dat;
  logic [IW-1:0] wb_idx;
  logic          fiq_vld_r, irq_vld_r, rd_busy, wb_full;

  wire [RAW:0]   a_ext     = {1'b0, reg_addr};
  wire           in_win    = (a_ext >= LO) && (a_ext < HI);
  wire [RAW-1:0] off       = reg_addr - LO[RAW-1:0];
  wire [IW-1:0]  r_idx     = off[IW+1:2];
  wire           look      = fiq_req | irq_req;
  wire           do_commit = wb_full & ~look;
  wire           do_read   = reg_valid & ~reg_write & in_win & ~wb_full & ~look & ~rd_busy;
  wire           wr_acc    = reg_valid & reg_write & in_win & ~wb_full;
  wire           any_vld   = fiq_vld_r | irq_vld_r;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[1:0], off[1:0], off[RAW-1:IW+2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (do_commit) begin
      mem[wb_idx] <= wb_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= '0;
    else if (fiq_req) q_r <= mem[fiq_idx];
    else if (irq_req) q_r <= mem[irq_idx];
    else if (do_read) q_r <= mem[r_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_vld_r <= 1'b0;
      irq_vld_r <= 1'b0;
      rd_busy   <= 1'b0;
      wb_full   <= 1'b0;
      wb_idx    <= '0;
      wb_dat    <= '0;
      last_r    <= '0;
    end else begin
      fiq_vld_r <= fiq_req;
      irq_vld_r <= irq_req & ~fiq_req;
      rd_busy   <= do_read;
      if (wr_acc) begin
        wb_full <= 1'b1;
        wb_idx  <= r_idx;
        wb_dat  <= reg_wdata[DW-1:2];
      end else if (do_commit) begin
        wb_full <= 1'b0;
      end
      if (any_vld) last_r <= q_r;
    end
  end

  assign fiq_vld   = fiq_vld_r;
  assign irq_vld   = irq_vld_r;
  assign fiq_vec   = {q_r, 2'b00};
  assign irq_vec   = {q_r, 2'b00};
  assign vec_addr  = {any_vld ? q_r : last_r, 2'b00};
  assign reg_ready = reg_valid & (~in_win | (reg_write ? ~wb_full : rd_busy));
  assign reg_rdata = (in_win & rd_busy) ? {q_r, 2'b00} : '0;
endmodule

// File: rtl/irq_vec_table_sva.sv
module irq_vec_table_sva #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fiq_req,
  input logic          irq_req,
  input logic          fiq_vld,
  input logic          irq_vld,
  input logic          reg_valid,
  input logic          reg_write,
  input logic          reg_ready,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] vec_addr,
  input logic          wb_full,
  input logic          in_win
);
  assert_fiq_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |=> fiq_vld && !irq_vld);
  assert_irq_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !fiq_req |=> irq_vld);
  assert_idle_no_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_req && !irq_req |=> !fiq_vld && !irq_vld);
  assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1:0] == 2'b00 && vec_addr[1:0] == 2'b00);
  assert_commit_first_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full && !fiq_req && !irq_req |=> !wb_full);
  assert_starve_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full && (fiq_req || irq_req) |=> wb_full);
  assert_read_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && in_win && reg_ready |-> !wb_full && $past(reg_valid && !reg_write));
  assert_outside_immediate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !in_win |-> reg_ready && (reg_write || reg_rdata == '0));
endmodule

bind irq_vec_table irq_vec_table_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .irq_req(irq_req),
  .fiq_vld(fiq_vld), .irq_vld(irq_vld), .reg_valid(reg_valid),
  .reg_write(reg_write), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
  .vec_addr(vec_addr), .wb_full(wb_full), .in_win(in_win)
);

// File: tb/tb_irq_vec_table.sv
module tb_irq_vec_table;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 256;
  localparam int DW = 32;
  localparam int RAW = 12;
  localparam int BASE = 'h400;
  localparam int IW = 8;

  logic clk = 0, rst_n = 0;
  logic fiq_req = 0, irq_req = 0, reg_valid = 0, reg_write = 0;
  logic [IW-1:0] fiq_idx = '0, irq_idx = '0;
  logic [RAW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic fiq_vld, irq_vld, reg_ready;
  logic [DW-1:0] fiq_vec, irq_vec, vec_addr, reg_rdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_table #(.ENTRIES(ENTRIES), .DW(DW), .RAW(RAW), .BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .fiq_idx(fiq_idx), .fiq_vld(fiq_vld),
    .fiq_vec(fiq_vec), .irq_req(irq_req), .irq_idx(irq_idx), .irq_vld(irq_vld),
    .irq_vec(irq_vec), .vec_addr(vec_addr), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata));

  function automatic logic [DW-1:0] wpat(int q);
    return (DW'(q) * 32'h0104_0A13) ^ 32'h5A3C_96E3;
  endfunction
  function automatic logic [DW-1:0] vexp(int q);
    return wpat(q) & 32'hFFFF_FFFC;
  endfunction
  function automatic logic [RAW-1:0] ent(int q);
    return RAW'(BASE + q * 4);
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_xfer(bit wr, logic [RAW-1:0] a, logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int waits);
    waits = 0;
    @(negedge clk);
    reg_valid = 1; reg_write = wr; reg_addr = a; reg_wdata = d;
    #1;
    while (!reg_ready && waits < 50) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = reg_rdata;
    @(posedge clk); #1;
    reg_valid = 0;
  endtask

  task automatic fiq_look(int q, logic [DW-1:0] exp, string req);
    @(negedge clk);
    fiq_req = 1; fiq_idx = IW'(q);
    @(negedge clk);
    fiq_req = 0;
    #1;
    chk(fiq_vld && !irq_vld && fiq_vec == exp, req, fiq_vec, exp);
    chk(vec_addr == exp, "R4", vec_addr, exp);
  endtask

  task automatic irq_look(int q, logic [DW-1:0] exp, string req);
    @(negedge clk);
    irq_req = 1; irq_idx = IW'(q);
    @(negedge clk);
    irq_req = 0;
    #1;
    chk(irq_vld && !fiq_vld && irq_vec == exp, req, irq_vec, exp);
    chk(vec_addr == exp, "R4", vec_addr, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog act=%h exp=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!fiq_vld && !irq_vld && vec_addr == '0, "R1", vec_addr, '0);
    fiq_look(200, '0, "R1");
    irq_look(17, '0, "R1");
    reg_xfer(0, ent(255), '0, rd, w);
    chk(rd == '0 && w == 1, "R1", rd, '0);

    // R5 R7: full sweep of writes; first accepted at once, each later one waits one commit cycle
    for (int q = 0; q < ENTRIES; q++) begin
      reg_xfer(1, ent(q), wpat(q), rd, w);
      chk(w == (q == 0 ? 0 : 1), "R7", DW'(w), DW'(q == 0 ? 0 : 1));
    end
    // R9 R6 readback of every entry
    for (int q = 0; q < ENTRIES; q++) begin
      reg_xfer(0, ent(q), '0, rd, w);
      chk(rd == vexp(q), "R9", rd, vexp(q));
      chk(rd[1:0] == 2'b00, "R6", rd, vexp(q));
    end
    for (int q = 0; q < ENTRIES; q++) fiq_look(q, vexp(q), "R2");
    for (int q = 0; q < ENTRIES; q += 3) irq_look(q, vexp(q), "R3");

    // R4 hold after idle
    fiq_look(77, vexp(77), "R2");
    @(negedge clk); #1;
    chk(!fiq_vld && vec_addr == vexp(77), "R4", vec_addr, vexp(77));

    // R3 simultaneous requests
    @(negedge clk);
    fiq_req = 1; fiq_idx = 8'd10; irq_req = 1; irq_idx = 8'd20;
    @(negedge clk);
    fiq_req = 0; #1;
    chk(fiq_vld && !irq_vld && fiq_vec == vexp(10), "R3", fiq_vec, vexp(10));
    @(negedge clk);
    irq_req = 0; #1;
    chk(irq_vld && !fiq_vld && irq_vec == vexp(20), "R3", irq_vec, vexp(20));

    // R10 out-of-window
    reg_xfer(0, 12'h000, '0, rd, w);
    chk(rd == '0 && w == 0, "R10", rd, '0);
    reg_xfer(1, 12'h800, 32'hFFFF_FFFF, rd, w);
    chk(w == 0, "R10", DW'(w), '0);
    reg_xfer(0, 12'h800, '0, rd, w);
    chk(rd == '0 && w == 0, "R10", rd, '0);
    reg_xfer(0, ent(0), '0, rd, w);
    chk(rd == vexp(0), "R10", rd, vexp(0));
    reg_xfer(1, 12'h3FC, 32'hFFFF_FFFF, rd, w);
    reg_xfer(0, ent(255), '0, rd, w);
    chk(rd == vexp(255), "R10", rd, vexp(255));

    // R7 R9 read right after write: commit, issue, complete
    reg_xfer(1, ent(9), 32'h1234_5677, rd, w);
    chk(w == 0, "R5", DW'(w), '0);
    reg_xfer(0, ent(9), '0, rd, w);
    chk(rd == 32'h1234_5674 && w == 2, "R9", rd, 32'h1234_5674);

    // R11 R8: starvation by continuous lookups
    @(negedge clk);
    fiq_req = 1; fiq_idx = 8'd5;
    reg_valid = 1; reg_write = 1; reg_addr = ent(5); reg_wdata = 32'hCAFE_BEEF;
    #1;
    chk(reg_ready, "R5", DW'(reg_ready), 1);
    @(posedge clk); #1;
    reg_valid = 0; irq_req = 1; irq_idx = 8'd5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(fiq_vld && fiq_vec == vexp(5), "R8", fiq_vec, vexp(5));
      chk(!irq_vld, "R3", DW'(irq_vld), 0);
    end
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = ent(5);
    #1;
    chk(!reg_ready, "R11", DW'(reg_ready), 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1;
      chk(!reg_ready, "R11", DW'(reg_ready), 0);
      chk(fiq_vec == vexp(5), "R8", fiq_vec, vexp(5));
    end
    @(negedge clk);
    fiq_req = 0; irq_req = 0; #1;
    chk(!reg_ready, "R7", DW'(reg_ready), 0);
    @(negedge clk); #1;
    chk(!reg_ready, "R9", DW'(reg_ready), 0);
    @(negedge clk); #1;
    chk(reg_ready && reg_rdata == 32'hCAFE_BEEC, "R9", reg_rdata, 32'hCAFE_BEEC);
    @(posedge clk); #1;
    reg_valid = 0;
    fiq_look(5, 32'hCAFE_BEEC, "R8");

    // R7 commit on first free cycle, then lookup sees new value
    @(negedge clk);
    fiq_req = 1; fiq_idx = 8'd7;
    reg_valid = 1; reg_write = 1; reg_addr = ent(7); reg_wdata = 32'h0BAD_F00D;
    @(posedge clk); #1;
    reg_valid = 0;
    @(negedge clk); #1;
    chk(fiq_vec == vexp(7), "R8", fiq_vec, vexp(7));
    @(negedge clk);
    fiq_req = 0;
    @(negedge clk);
    fiq_req = 1;
    @(negedge clk);
    fiq_req = 0; #1;
    chk(fiq_vld && fiq_vec == 32'h0BAD_F00C, "R7", fiq_vec, 32'h0BAD_F00C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule